// File: doc/BRIEF.md
# Multiplexed BCD Digit Scanner

This block presents a set of stored BCD digits, one at a time, on a single shared four-bit bus. For each digit it pulls a matching digit-select line low. A display driver uses the bus and the selects to light one digit position at a time, and the scan moves fast enough that all digits appear lit together. The default build handles three digits. They arrive packed into one vector with the least significant digit in the lowest nibble.

A scan tick moves the scan on by one position. The tick comes from one of two sources. The first is an internal prescaler that divides the system clock by a programmable value. The second is an external scan-clock pin, which is brought into the clock domain through a two-flop synchronizer and reduced to its rising edges. An active-high master reset parks the scan on the first digit and drives every select inactive. It also stops the scan source, so no tick is counted while it is asserted.

Top module: `bcd_scan_mux`

## Requirements
- R1: The bus `bcd_o` carries the digit whose select is low, in active-high form. Digit i is taken from bits 4i+3 down to 4i of `digits_i`, and the bus changes in the same cycle as the select.
- R2: Outside master reset, exactly one bit of `sel_n_o` is low in every cycle. Bit 0 belongs to the least significant digit.
- R3: Each scan tick moves the low select by one position in the order digit 1, digit 2, digit 3, then back to digit 1.
- R4: While `mrst_i` is high, every bit of `sel_n_o` is high in the same cycle and `bcd_o` shows digit 1.
- R5: While `mrst_i` is high, the scan does not advance, whatever the scan source does.
- R6: After `mrst_i` falls, digit 1 is the first digit selected. In prescaler mode it stays selected for a full divide period.
- R7: With `src_sel_i` = 0 (prescaler), the scan advances once every `div_i` clock cycles. A `div_i` of 0 behaves as 1.
- R8: With `src_sel_i` = 1 (external), each rising edge on `ext_scan_i` advances the scan exactly once. The new digit appears after the third rising clock edge that follows the input change. A held level causes no further steps.
- R9: With `src_sel_i` = 0, activity on `ext_scan_i` has no effect on the scan.
- R10: In external mode, a rising edge on `ext_scan_i` that happens while `mrst_i` is high is dropped and does not produce a step after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| mrst_i | input | 1 | Active-high master reset; parks the scan and blanks the selects |
| src_sel_i | input | 1 | Scan source: 0 selects the prescaler, 1 selects the external scan pin |
| ext_scan_i | input | 1 | External scan clock; asynchronous to clk_i |
| div_i | input | DIV_W | Prescaler divide value, in clock cycles per scan step |
| digits_i | input | NUM_DIGITS*4 | Packed BCD digits, least significant in the lowest nibble |
| bcd_o | output | 4 | Active-high BCD value of the selected digit |
| sel_n_o | output | NUM_DIGITS | Active-low digit selects, bit 0 for the least significant digit |

## Verification
The properties assume that `src_sel_i` and `div_i` change only while master reset is held. The bench therefore sets both inside a reset period. The rule that edges arriving during reset are dropped depends on `ext_scan_i` having been stable for at least three clocks before `mrst_i` falls, so the bench keeps every reset period well beyond that after its last input change. External scan pulses are held high and low for several clocks each, so no pulse is shorter than the synchronizer can resolve.

// File: rtl/scan_pkg.sv
package scan_pkg;

    typedef enum logic {
        SRC_PRESCALE = 1'b0,
        SRC_EXTERNAL = 1'b1
    } scan_src_e;

    // three-stage capture of the asynchronous scan pin: two for sync, one for edge
    typedef struct packed {
        logic meta;
        logic sync;
        logic prev;
    } ext_sync_t;

endpackage

// File: rtl/scan_tick_gen.sv
module scan_tick_gen
    import scan_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic             clk_i,
    input  logic             mrst_i,
    input  scan_src_e        src_i,
    input  logic             ext_scan_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        ext_sync_t        ext;
    } tick_state_t;

    tick_state_t st_d, st_q;
    logic [DIV_W-1:0] limit;
    logic             pre_tick;
    logic             ext_rise;

    always_comb begin
        st_d     = st_q;
        limit    = (div_i == '0) ? '0 : div_i - 1'b1;
        pre_tick = (st_q.cnt >= limit);
        ext_rise = st_q.ext.sync & ~st_q.ext.prev;

        // synchronizer keeps shifting during reset so an edge seen then is absorbed
        st_d.ext.meta = ext_scan_i;
        st_d.ext.sync = st_q.ext.meta;
        st_d.ext.prev = st_q.ext.sync;

        if (mrst_i || src_i == SRC_EXTERNAL) begin
            st_d.cnt = '0;
        end else if (pre_tick) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end

        if (mrst_i) begin
            tick_o = 1'b0;
        end else if (src_i == SRC_EXTERNAL) begin
            tick_o = ext_rise;
        end else begin
            tick_o = pre_tick;
        end
    end

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

endmodule

// File: rtl/scan_pointer.sv
module scan_pointer #(
    parameter int NUM_DIGITS = 3,
    localparam int PTR_W = (NUM_DIGITS > 1) ? $clog2(NUM_DIGITS) : 1
) (
    input  logic             clk_i,
    input  logic             mrst_i,
    input  logic             tick_i,
    output logic [PTR_W-1:0] pos_o
);

    localparam logic [PTR_W-1:0] LAST = PTR_W'(NUM_DIGITS - 1);

    typedef struct packed {
        logic [PTR_W-1:0] pos;
    } ptr_state_t;

    ptr_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (mrst_i) begin
            st_d.pos = '0;
        end else if (tick_i) begin
            st_d.pos = (st_q.pos == LAST) ? '0 : st_q.pos + 1'b1;
        end
        pos_o = st_q.pos;
    end

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

endmodule

// File: rtl/digit_mux.sv
module digit_mux #(
    parameter int NUM_DIGITS = 3,
    localparam int PTR_W = (NUM_DIGITS > 1) ? $clog2(NUM_DIGITS) : 1
) (
    input  logic                    mrst_i,
    input  logic [PTR_W-1:0]        pos_i,
    input  logic [NUM_DIGITS*4-1:0] digits_i,
    output logic [3:0]              bcd_o,
    output logic [NUM_DIGITS-1:0]   sel_n_o
);

    logic [PTR_W-1:0] eff_pos;

    always_comb begin
        // the stored position may lag reset by one edge; show digit one at once
        eff_pos = mrst_i ? '0 : pos_i;
        bcd_o   = digits_i[eff_pos*4 +: 4];
        for (int i = 0; i < NUM_DIGITS; i++) begin
            sel_n_o[i] = mrst_i | (eff_pos != PTR_W'(i));
        end
    end

endmodule

// File: rtl/bcd_scan_mux.sv
module bcd_scan_mux #(
    parameter int NUM_DIGITS = 3,
    parameter int DIV_W      = 16
) (
    input  logic                    clk_i,
    input  logic                    mrst_i,
    input  logic                    src_sel_i,
    input  logic                    ext_scan_i,
    input  logic [DIV_W-1:0]        div_i,
    input  logic [NUM_DIGITS*4-1:0] digits_i,
    output logic [3:0]              bcd_o,
    output logic [NUM_DIGITS-1:0]   sel_n_o
);

    import scan_pkg::*;

    localparam int PTR_W = (NUM_DIGITS > 1) ? $clog2(NUM_DIGITS) : 1;

    logic             tick;
    logic [PTR_W-1:0] pos;
    scan_src_e        src;

    assign src = scan_src_e'(src_sel_i);

    scan_tick_gen #(.DIV_W(DIV_W)) u_tick (
        .clk_i      (clk_i),
        .mrst_i     (mrst_i),
        .src_i      (src),
        .ext_scan_i (ext_scan_i),
        .div_i      (div_i),
        .tick_o     (tick)
    );

    scan_pointer #(.NUM_DIGITS(NUM_DIGITS)) u_ptr (
        .clk_i  (clk_i),
        .mrst_i (mrst_i),
        .tick_i (tick),
        .pos_o  (pos)
    );

    digit_mux #(.NUM_DIGITS(NUM_DIGITS)) u_mux (
        .mrst_i   (mrst_i),
        .pos_i    (pos),
        .digits_i (digits_i),
        .bcd_o    (bcd_o),
        .sel_n_o  (sel_n_o)
    );

endmodule

// File: rtl/bcd_scan_mux_checker.sv
module bcd_scan_mux_checker #(
    parameter int NUM_DIGITS = 3
) (
    input logic                    clk_i,
    input logic                    mrst_i,
    input logic [NUM_DIGITS*4-1:0] digits_i,
    input logic [3:0]              bcd_o,
    input logic [NUM_DIGITS-1:0]   sel_n_o
);

    p_one_select_r2: assert property (@(posedge clk_i) disable iff (mrst_i)
        $countones(~sel_n_o) == 1);

    p_blank_in_reset_r4: assert property (@(posedge clk_i)
        mrst_i |-> (sel_n_o == '1 && bcd_o == digits_i[3:0]));

    p_first_digit_r6: assert property (@(posedge clk_i) disable iff (mrst_i)
        $fell(mrst_i) |-> sel_n_o[0] == 1'b0);

    generate
        for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_follow
            p_bcd_follow_r1: assert property (@(posedge clk_i) disable iff (mrst_i)
                !sel_n_o[g] |-> bcd_o == digits_i[g*4 +: 4]);
        end
        if (NUM_DIGITS > 1) begin : g_rot
            p_rotation_r3: assert property (@(posedge clk_i) disable iff (mrst_i)
                (!$past(mrst_i) && !$stable(sel_n_o)) |->
                sel_n_o == {$past(sel_n_o[NUM_DIGITS-2:0]), $past(sel_n_o[NUM_DIGITS-1])});
        end
    endgenerate

endmodule

bind bcd_scan_mux bcd_scan_mux_checker #(.NUM_DIGITS(NUM_DIGITS)) u_checker (
    .clk_i    (clk_i),
    .mrst_i   (mrst_i),
    .digits_i (digits_i),
    .bcd_o    (bcd_o),
    .sel_n_o  (sel_n_o)
);

// File: tb/tb_bcd_scan_mux.sv
module tb_bcd_scan_mux;

    localparam int N  = 3;
    localparam int DW = 16;

    logic            clk = 1'b0;
    logic            mrst;
    logic            src_sel;
    logic            ext_scan;
    logic [DW-1:0]   div;
    logic [N*4-1:0]  digits;
    logic [3:0]      bcd;
    logic [N-1:0]    sel_n;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    bcd_scan_mux #(.NUM_DIGITS(N), .DIV_W(DW)) dut (
        .clk_i      (clk),
        .mrst_i     (mrst),
        .src_sel_i  (src_sel),
        .ext_scan_i (ext_scan),
        .div_i      (div),
        .digits_i   (digits),
        .bcd_o      (bcd),
        .sel_n_o    (sel_n)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // expected outputs when digit p is shown
    task automatic expect_pos(input string req, input int p);
        chk(req, int'(sel_n), int'(~(3'b001 << p) & 3'b111));
        chk({req, "/R1"}, int'(bcd), int'(digits[p*4 +: 4]));
    endtask

    task automatic enter_reset(input logic src, input int d);
        @(negedge clk);
        mrst    = 1'b1;
        src_sel = src;
        div     = DW'(d);
        repeat (5) @(negedge clk);
    endtask

    task automatic release_reset();
        mrst = 1'b0;
        #1;
    endtask

    task automatic t_reset_state();
        enter_reset(1'b0, 4);
        for (int k = 0; k < 8; k++) begin
            chk("R4 sel blank", int'(sel_n), 7);
            chk("R4 bcd digit1", int'(bcd), int'(digits[3:0]));
            @(negedge clk);
        end
    endtask

    // prescaler run: after release digit p=(j/d)%3 is shown at sample j
    task automatic t_prescale(input int d, input int samples, input logic toggle_ext);
        int eff;
        eff = (d == 0) ? 1 : d;
        enter_reset(1'b0, d);
        release_reset();
        for (int j = 0; j < samples; j++) begin
            if (j == 0) expect_pos("R6 first digit", 0);
            else if (toggle_ext) expect_pos("R9 ext ignored", (j / eff) % N);
            else expect_pos("R7/R3 prescale step", (j / eff) % N);
            @(negedge clk);
            if (toggle_ext) ext_scan = ~ext_scan;
        end
        ext_scan = 1'b0;
    endtask

    task automatic t_external();
        int p;
        ext_scan = 1'b0;
        enter_reset(1'b1, 2);
        release_reset();
        expect_pos("R6 ext first", 0);
        p = 0;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            ext_scan = 1'b1;
            @(negedge clk);
            @(negedge clk);
            expect_pos("R8 not yet", p);
            @(negedge clk);
            p = (p + 1) % N;
            expect_pos("R8 one step", p);
            repeat (3) @(negedge clk);
            expect_pos("R8 held high", p);
            ext_scan = 1'b0;
            repeat (3) @(negedge clk);
            expect_pos("R8 low no step", p);
        end
    endtask

    task automatic t_ext_in_reset();
        enter_reset(1'b1, 2);
        ext_scan = 1'b1;
        repeat (5) @(negedge clk);
        release_reset();
        for (int j = 0; j < 6; j++) begin
            expect_pos("R10 edge dropped", 0);
            @(negedge clk);
        end
        ext_scan = 1'b0;
        repeat (3) @(negedge clk);
        expect_pos("R10 fall no step", 0);
    endtask

    task automatic t_mid_scan_reset();
        enter_reset(1'b0, 1);
        release_reset();
        @(negedge clk);
        @(negedge clk);
        expect_pos("R3 at digit3", 2);
        mrst = 1'b1;
        #1;
        chk("R4 immediate blank", int'(sel_n), 7);
        chk("R4 immediate bcd", int'(bcd), int'(digits[3:0]));
        for (int j = 0; j < 6; j++) begin
            @(negedge clk);
            chk("R5 no scan in reset", int'(sel_n), 7);
        end
        release_reset();
        expect_pos("R6 restart digit1", 0);
        @(negedge clk);
        expect_pos("R3 next digit2", 1);
    endtask

    initial begin
        mrst     = 1'b1;
        src_sel  = 1'b0;
        ext_scan = 1'b0;
        div      = DW'(4);
        digits   = 12'h947;
        t_reset_state();
        t_prescale(4, 30, 1'b0);
        digits = 12'h380;
        t_prescale(1, 10, 1'b0);
        t_prescale(0, 8, 1'b0);
        digits = 12'h526;
        t_prescale(3, 20, 1'b1);
        t_external();
        t_ext_in_reset();
        digits = 12'h691;
        t_mid_scan_reset();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #(8 * 200000);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule